// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block reads 32-bit words from a single bank of external asynchronous parallel memory that has a 16-bit data bus. A requester presents a word index and a one-cycle request. The sequencer then performs two halfword reads, one after the other. Each read is shaped by a timing template made of three phases: setup, access and hold. The length of each phase is a count of system clock cycles. The external byte address is a fixed base (default 0x2000_0000) plus four times the word index. The lower halfword is read first and the upper halfword second. The two are combined into one 32-bit result, which is returned with a single-cycle valid pulse.

After reset the template holds the slowest settings: 4 setup cycles, 15 access cycles and 3 hold cycles. This lets any attached device be read before software has tuned the timing. The three counts can be rewritten through a configuration strobe while the block is idle.

The sequencer is a four-state machine:
- IDLE goes to SETUP when a request arrives (*accept*).
- SETUP goes to ACCESS on its last counted cycle (*setup done*).
- ACCESS goes to HOLD on its last cycle (*access done*); the data bus is sampled on that edge.
- HOLD goes back to SETUP for the upper halfword (*next half*) after the first hold phase.
- HOLD goes to IDLE after the second hold phase (*finish*), which also raises the result valid pulse.

Top module: `async_rd_seq`

## Requirements
- R1: After reset, mem_cs_n and mem_rd_n are 1, and busy and rsp_valid are 0. The template is 4 setup, 15 access and 3 hold cycles, so the first read occupies 44 busy cycles.
- R2: In the first cycle after a request is accepted, mem_cs_n and mem_rd_n are both 0. mem_addr is BASE + 4*req_word for the lower halfword and BASE + 4*req_word + 2 for the upper halfword.
- R3: mem_rd_n stays 0 through setup and access and returns to 1 in the first hold cycle. mem_cs_n stays 0 through hold. Both are 1 whenever busy is 0.
- R4: With effective counts S, A and H, each halfword read spends S cycles in setup, A cycles in access and H cycles in hold. busy is high for exactly 2*(S+A+H) cycles.
- R5: A programmed count of 0 behaves as a count of 1.
- R6: mem_data is sampled only on the last access cycle of each halfword read.
- R7: rsp_data[15:0] holds the halfword from the lower address and rsp_data[31:16] holds the halfword from the upper address. rsp_valid is a one-cycle pulse in the first cycle after the final hold cycle, when busy is already 0.
- R8: busy rises in the cycle after a request is sampled while idle. A req asserted while busy is ignored: it produces no extra result and does not change the address.
- R9: A cfg_we pulse while idle loads cfg_setup, cfg_access and cfg_hold for later reads. A cfg_we pulse while busy has no effect.
- R10: mem_addr is stable for the whole of each halfword read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the timing counts |
| cfg_setup | input | CNT_W | Setup cycle count |
| cfg_access | input | CNT_W | Access cycle count |
| cfg_hold | input | CNT_W | Hold cycle count |
| req | input | 1 | Read request |
| req_word | input | WA_W | Word index relative to the base |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 2*DQ_W | Packed 32-bit result |
| mem_addr | output | ADDR_W | External byte address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_data | input | DQ_W | External data bus |

## Verification
The assertions check the strobe relationships on every cycle:
- the read strobe is never active without chip select;
- both strobes are inactive when idle;
- both strobes are active at the start of a transaction, and busy only rises after a request;
- the address does not move within a halfword read;
- the valid pulse lasts one cycle and only follows busy;
- the timing counts cannot change while busy.

Only the bench's scenarios can show the exact phase lengths for a given template, the zero-as-one rule, and the exact sampling cycle. The bench's memory model drives valid data only in the final access cycle. The same applies to the halfword order in the packed word and to requests and configuration writes that are dropped while busy.

// File: rtl/ars_pkg.sv
package ars_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_HOLD   = 2'd3
    } ars_state_e;

    localparam int N_PHASE   = 3;
    localparam int PH_SETUP  = 0;
    localparam int PH_ACCESS = 1;
    localparam int PH_HOLD   = 2;
endpackage

// File: rtl/ars_timing_regs.sv
module ars_timing_regs
    import ars_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int DEF_SETUP  = 4,
    parameter int DEF_ACCESS = 15,
    parameter int DEF_HOLD   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [N_PHASE-1:0][CNT_W-1:0]   wr_val,
    output logic [N_PHASE-1:0][CNT_W-1:0]   eff
);
    localparam logic [N_PHASE-1:0][CNT_W-1:0] DEFS =
        {CNT_W'(DEF_HOLD), CNT_W'(DEF_ACCESS), CNT_W'(DEF_SETUP)};

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        logic [CNT_W-1:0] raw_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q <= DEFS[g];
            end else if (wr_en) begin
                raw_q <= wr_val[g];
            end
        end

        // a programmed zero stretches to one cycle
        assign eff[g] = (raw_q == '0) ? CNT_W'(1) : raw_q;
    end
endmodule

// File: rtl/ars_phase_ctr.sv
module ars_phase_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ars_packer.sv
module ars_packer #(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              done,
    input  logic [DQ_W-1:0]   din,
    output logic              valid,
    output logic [2*DQ_W-1:0] word
);
    logic [DQ_W-1:0] lo_q;
    logic [DQ_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            valid <= 1'b0;
        end else begin
            if (cap_lo) lo_q <= din;
            if (cap_hi) hi_q <= din;
            valid <= done;
        end
    end

    assign word = {hi_q, lo_q};
endmodule

// File: rtl/async_rd_seq.sv
module async_rd_seq
    import ars_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              WA_W       = 20,
    parameter int              DQ_W       = 16,
    parameter int              CNT_W      = 5,
    parameter logic [31:0]     BASE_ADDR  = 32'h2000_0000,
    parameter int              DEF_SETUP  = 4,
    parameter int              DEF_ACCESS = 15,
    parameter int              DEF_HOLD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_access,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              req,
    input  logic [WA_W-1:0]   req_word,
    output logic              busy,
    output logic              rsp_valid,
    output logic [2*DQ_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DQ_W-1:0]   mem_data
);
    localparam int BYTE_SH = $clog2(2 * DQ_W / 8);
    localparam int HALF_B  = DQ_W / 8;

    ars_state_e                      state_q, state_d;
    logic                            half_q;
    logic [WA_W-1:0]                 word_q;
    logic [N_PHASE-1:0][CNT_W-1:0]   eff_cnt;
    logic [N_PHASE-1:0][CNT_W-1:0]   cfg_vec;
    logic [CNT_W-1:0]                limit;
    logic                            ph_last;
    logic                            ph_run;
    logic                            cap_lo, cap_hi, done;

    assign cfg_vec = {cfg_hold, cfg_access, cfg_setup};

    ars_timing_regs #(
        .CNT_W(CNT_W), .DEF_SETUP(DEF_SETUP),
        .DEF_ACCESS(DEF_ACCESS), .DEF_HOLD(DEF_HOLD)
    ) u_tmg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (state_q == ST_IDLE)),
        .wr_val(cfg_vec), .eff(eff_cnt)
    );

    always_comb begin
        unique case (state_q)
            ST_SETUP:  limit = eff_cnt[PH_SETUP];
            ST_ACCESS: limit = eff_cnt[PH_ACCESS];
            default:   limit = eff_cnt[PH_HOLD];
        endcase
    end

    assign ph_run = (state_q != ST_IDLE);

    ars_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(ph_run), .limit(limit), .last(ph_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req)     state_d = ST_SETUP;
            ST_SETUP:  if (ph_last) state_d = ST_ACCESS;
            ST_ACCESS: if (ph_last) state_d = ST_HOLD;
            ST_HOLD:   if (ph_last) state_d = half_q ? ST_IDLE : ST_SETUP;
        endcase
    end

    // state register plus transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                half_q <= 1'b0;
                word_q <= req_word;
            end else if (state_q == ST_HOLD && ph_last && !half_q) begin
                half_q <= 1'b1;
            end
        end
    end

    assign cap_lo = (state_q == ST_ACCESS) && ph_last && !half_q;
    assign cap_hi = (state_q == ST_ACCESS) && ph_last &&  half_q;
    assign done   = (state_q == ST_HOLD)   && ph_last &&  half_q;

    ars_packer #(.DQ_W(DQ_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .done(done), .din(mem_data), .valid(rsp_valid), .word(rsp_data)
    );

    // outputs decoded from the state
    always_comb begin
        mem_addr = ADDR_W'(BASE_ADDR) + (ADDR_W'(word_q) << BYTE_SH)
                 + (half_q ? ADDR_W'(HALF_B) : '0);
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; mem_cs_n = 1'b1; mem_rd_n = 1'b1; end
            ST_SETUP,
            ST_ACCESS: begin busy = 1'b1; mem_cs_n = 1'b0; mem_rd_n = 1'b0; end
            ST_HOLD:   begin busy = 1'b1; mem_cs_n = 1'b0; mem_rd_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ars_chk.sv
module ars_chk
    import ars_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req,
    input logic                          cfg_we,
    input logic                          busy,
    input logic                          rsp_valid,
    input logic [ADDR_W-1:0]             mem_addr,
    input logic                          mem_cs_n,
    input logic                          mem_rd_n,
    input logic [N_PHASE-1:0][CNT_W-1:0] eff_cnt
);
    a_r3_rd_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_cs_n);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_rd_n));

    a_r2_start_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!mem_cs_n && !mem_rd_n));

    a_r8_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n) && !$fell(mem_rd_n)) |-> $stable(mem_addr));

    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!busy && $past(busy)));

    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> $stable(eff_cnt));
endmodule

bind async_rd_seq ars_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .busy(busy),
    .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .eff_cnt(eff_cnt)
);

// File: tb/sim_async_rd_seq.sv
module sim_async_rd_seq;
    localparam int          CLK_PERIOD = 10;
    localparam int          WA_W  = 20;
    localparam int          CNT_W = 5;
    localparam logic [31:0] BASE  = 32'h2000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CNT_W-1:0]  cfg_setup = '0, cfg_access = '0, cfg_hold = '0;
    logic              req = 1'b0;
    logic [WA_W-1:0]   req_word = '0;
    logic              busy, rsp_valid, mem_cs_n, mem_rd_n;
    logic [31:0]       rsp_data, mem_addr;
    logic [15:0]       mem_data;

    int n_cmp = 0, n_bad = 0;
    int eS = 4, eA = 15, eH = 3;
    logic [WA_W-1:0] cur_word = '0;
    int rdcnt = 0;
    bit finished = 1'b0;

    logic [31:0] q_data[$];
    int          q_len[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
        .cfg_access(cfg_access), .cfg_hold(cfg_hold), .req(req),
        .req_word(req_word), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_data(mem_data)
    );

    function automatic logic [15:0] mem_f(logic [31:0] a);
        return a[15:0] ^ {a[7:0], a[31:24]} ^ 16'h5A3C;
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // memory model: valid data only on the last access cycle (R6)
    always @(posedge clk) rdcnt <= (!mem_rd_n) ? rdcnt + 1 : 0;
    assign mem_data = (!mem_rd_n && rdcnt == eS + eA - 1) ? mem_f(mem_addr) : 16'hBAD0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [WA_W-1:0] w);
        logic [31:0] a;
        a = BASE + (32'(w) << 2);
        @(negedge clk);
        req = 1'b1; req_word = w;
        cur_word = w;
        q_data.push_back({mem_f(a + 32'd2), mem_f(a)});
        q_len.push_back(2 * (eS + eA + eH));
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic set_cfg(int s, int a, int h, bit honored);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_setup = CNT_W'(s); cfg_access = CNT_W'(a); cfg_hold = CNT_W'(h);
        if (honored) begin eS = eff(s); eA = eff(a); eH = eff(h); end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // scoreboard monitor: results and busy length (R4, R7, R8)
    int blen = 0;
    always @(negedge clk) if (rst_n) begin
        if (rsp_valid) begin
            if (q_data.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8 actual=unexpected result %h expected=none", rsp_data);
            end else begin
                check("R7 packed data", rsp_data, q_data.pop_front());
                check("R7 busy low with valid", 32'(busy), 32'd0);
            end
        end
        if (busy) blen++;
        else if (blen > 0) begin
            if (q_len.size() == 0) check("R8 stray busy", 32'(blen), 32'd0);
            else check("R4 busy length", 32'(blen), 32'(q_len.pop_front()));
            blen = 0;
        end
    end

    // protocol monitor: strobes and address per cycle (R2, R3, R10)
    int idx = 0;
    always @(negedge clk) if (rst_n) begin
        if (busy) begin
            int t, p;
            logic [31:0] ea;
            idx++;
            t = eS + eA + eH;
            p = ((idx - 1) % t) + 1;
            ea = BASE + (32'(cur_word) << 2) + ((idx > t) ? 32'd2 : 32'd0);
            check("R3 rd strobe phase", 32'(mem_rd_n), (p > eS + eA) ? 32'd1 : 32'd0);
            check("R3 cs held", 32'(mem_cs_n), 32'd0);
            check("R2 R10 address", mem_addr, ea);
        end else begin
            idx = 0;
            check("R3 idle strobes", {30'd0, mem_cs_n, mem_rd_n}, 32'd3);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", 32'(mem_cs_n), 32'd1);
        check("R1 rd_n", 32'(mem_rd_n), 32'd1);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 valid", 32'(rsp_valid), 32'd0);
        // R1 default slow template, R7 packing at the base address
        issue(20'd0);
        @(negedge clk);
        check("R2 start strobes", {30'd0, mem_cs_n, mem_rd_n}, 32'd0);
        wait_idle();
        issue(20'h0_0005); wait_idle();
        // R4 custom template
        set_cfg(2, 3, 1, 1'b1);
        issue(20'h1_2345); wait_idle();
        issue(20'hF_FFFF); wait_idle();
        // R5 zeros act as one
        set_cfg(0, 0, 0, 1'b1);
        issue(20'h0_00A7); wait_idle();
        set_cfg(0, 6, 0, 1'b1);
        issue(20'h0_3C00); wait_idle();
        // R8 request while busy is ignored
        set_cfg(3, 4, 2, 1'b1);
        issue(20'h0_0111);
        @(negedge clk);
        req = 1'b1; req_word = 20'h0_0999;
        @(negedge clk);
        req = 1'b0;
        wait_idle();
        // R9 config write while busy is ignored
        issue(20'h0_0222);
        set_cfg(1, 1, 1, 1'b0);
        wait_idle();
        issue(20'h0_0333); wait_idle();
        // back to the R1-style slowest timing via write
        set_cfg(4, 15, 3, 1'b1);
        issue(20'h0_0444); wait_idle();
        repeat (3) @(negedge clk);
        check("R8 no pending results", 32'(q_data.size()), 32'd0);
        check("R8 no pending lengths", 32'(q_len.size()), 32'd0);
        summary();
    end
endmodule